// File: doc/BRIEF.md
# Next Program Counter Branch Unit

This block works out the address of the next instruction for a byte-oriented microcontroller with a 16-bit program space. Each cycle it takes the address of the current instruction, the instruction's length in bytes, the opcode byte, up to two operand bytes, the accumulator, the data pointer and a taken flag. It also takes a small flow code that says which kind of control transfer the instruction performs. The resulting address is registered and appears on `next_pc` one clock edge later.

Five flows are covered: plain sequential stepping, jumps and calls inside the current 2 KB block, long jumps and calls to any 16-bit address, relative branches that depend on the taken flag, and the indirect jump through accumulator plus data pointer. Every target except the long and indirect ones is built from the advanced address, which is the current address plus the instruction length. All address arithmetic wraps modulo 65536. Decoding the opcode into a flow code and evaluating branch conditions are done outside this block.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `next_pc` is loaded with the parameter `RESET_VEC` (default 0000h), whatever the other inputs are.
- R2: With flow code 0 (sequential), `next_pc` becomes `cur_pc + instr_len` after the next rising edge.
- R3: With flow code 1 (in-block jump or call), `next_pc` is the concatenation of bits 15..11 of the advanced address, bits 7..5 of `opcode`, and `operand1`.
- R4: For flow code 1, the upper five bits come from the advanced address and not from `cur_pc`. A 2-byte jump at 07FEh therefore lands in the block that starts at 0800h.
- R5: With flow code 2 (long), `next_pc` is `{operand1, operand2}`, with operand1 as the high byte.
- R6: With flow code 3 (relative) and `taken` high, `next_pc` is the advanced address plus the sign-extended offset byte. The offset byte is the last byte of the instruction: `operand2` when `instr_len` is 3, otherwise `operand1`. The offset range is -128 to +127.
- R7: With flow code 3 and `taken` low, `next_pc` is the advanced address.
- R8: With flow code 4 (indirect), `next_pc` is `dptr` plus the zero-extended `acc`.
- R9: All sums wrap modulo 2^16, both forward past FFFFh and backward below 0000h.
- R10: Flow codes 5, 6 and 7 behave exactly like flow code 0.
- R11: `taken` has no effect for flow codes 0, 1, 2 and 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | 16 | Address of the first byte of the current instruction |
| instr_len | input | 2 | Instruction length in bytes |
| flow | input | 3 | Flow code: 0 seq, 1 in-block, 2 long, 3 relative, 4 indirect |
| opcode | input | 8 | Opcode byte; bits 7..5 feed the in-block target |
| operand1 | input | 8 | First operand byte |
| operand2 | input | 8 | Second operand byte |
| acc | input | 8 | Accumulator value |
| dptr | input | 16 | Data pointer value |
| taken | input | 1 | Branch condition for relative flows |
| next_pc | output | 16 | Registered next instruction address |

## Verification
Two operations share a single cycle: advancing past the instruction and forming the in-block or relative target. A wrong order therefore shows up only when the advance itself crosses a boundary. The bench provokes this in three ways: an in-block jump at the last two bytes of a 2 KB block, a relative branch whose advance wraps past FFFFh, and a backward branch just after 0000h. In each case the expected address is computed from the advanced value. Any result built from `cur_pc` lands in the wrong block or on the wrong side of zero.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

    localparam int PC_W   = 16;
    localparam int BYTE_W = 8;
    localparam int LEN_W  = 2;
    localparam int FLOW_W = 3;
    localparam int PAGE_W = 11;
    localparam int SEL_W  = 3;

    typedef enum logic [FLOW_W-1:0] {
        FLOW_SEQ   = 3'd0,
        FLOW_PAGE  = 3'd1,
        FLOW_LONG  = 3'd2,
        FLOW_REL   = 3'd3,
        FLOW_INDIR = 3'd4
    } flow_e;

    typedef struct packed {
        logic [PC_W-1:0] page;
        logic [PC_W-1:0] long_a;
        logic [PC_W-1:0] rel;
        logic [PC_W-1:0] indir;
    } tgt_set_t;

    // unknown flow codes fall back to sequential stepping
    function automatic flow_e flow_decode(input logic [FLOW_W-1:0] code);
        case (code)
            3'd1:    return FLOW_PAGE;
            3'd2:    return FLOW_LONG;
            3'd3:    return FLOW_REL;
            3'd4:    return FLOW_INDIR;
            default: return FLOW_SEQ;
        endcase
    endfunction

    function automatic logic [PC_W-1:0] sext_byte(input logic [BYTE_W-1:0] b);
        return {{(PC_W-BYTE_W){b[BYTE_W-1]}}, b};
    endfunction

    function automatic logic [PC_W-1:0] page_target(
        input logic [PC_W-1:0]   adv,
        input logic [BYTE_W-1:0] opc,
        input logic [BYTE_W-1:0] lo
    );
        return {adv[PC_W-1:PAGE_W], opc[BYTE_W-1:BYTE_W-SEL_W], lo};
    endfunction

endpackage

// File: rtl/nextpc_advance.sv
module nextpc_advance
    import nextpc_pkg::*;
#(
    parameter int W  = PC_W,
    parameter int LW = LEN_W
) (
    input  logic [W-1:0]  pc,
    input  logic [LW-1:0] len,
    output logic [W-1:0]  adv
);
    localparam int PAD = W - LW;

    always_comb begin
        adv = pc + {{PAD{1'b0}}, len};
    end
endmodule

// File: rtl/nextpc_targets.sv
module nextpc_targets
    import nextpc_pkg::*;
#(
    parameter bit OFFSET_LAST_BYTE = 1'b1
) (
    input  logic [PC_W-1:0]   adv,
    input  logic [LEN_W-1:0]  len,
    input  logic [BYTE_W-1:0] opcode,
    input  logic [BYTE_W-1:0] op1,
    input  logic [BYTE_W-1:0] op2,
    input  logic [BYTE_W-1:0] acc,
    input  logic [PC_W-1:0]   dptr,
    output tgt_set_t          tgts
);
    localparam int ACC_PAD = PC_W - BYTE_W;
    logic [BYTE_W-1:0] rel_byte;

    generate
        if (OFFSET_LAST_BYTE) begin : g_last
            always_comb rel_byte = (len == LEN_W'(3)) ? op2 : op1;
        end else begin : g_first
            logic unused_sel;
            always_comb begin
                rel_byte   = op1;
                unused_sel = ^{len, op2};
            end
        end
    endgenerate

    always_comb begin
        tgts.page   = page_target(adv, opcode, op1);
        tgts.long_a = {op1, op2};
        tgts.rel    = adv + sext_byte(rel_byte);
        tgts.indir  = dptr + {{ACC_PAD{1'b0}}, acc};
    end
endmodule

// File: rtl/nextpc_select.sv
module nextpc_select
    import nextpc_pkg::*;
(
    input  flow_e           kind,
    input  logic            taken,
    input  logic [PC_W-1:0] adv,
    input  tgt_set_t        tgts,
    output logic [PC_W-1:0] nxt
);
    always_comb begin
        case (kind)
            FLOW_PAGE:  nxt = tgts.page;
            FLOW_LONG:  nxt = tgts.long_a;
            FLOW_REL:   nxt = taken ? tgts.rel : adv;
            FLOW_INDIR: nxt = tgts.indir;
            default:    nxt = adv;
        endcase
    end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
    import nextpc_pkg::*;
#(
    parameter logic [PC_W-1:0] RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [LEN_W-1:0]  instr_len,
    input  logic [FLOW_W-1:0] flow,
    input  logic [BYTE_W-1:0] opcode,
    input  logic [BYTE_W-1:0] operand1,
    input  logic [BYTE_W-1:0] operand2,
    input  logic [BYTE_W-1:0] acc,
    input  logic [PC_W-1:0]   dptr,
    input  logic              taken,
    output logic [PC_W-1:0]   next_pc
);
    localparam int LEN_PAD = PC_W - LEN_W;
    localparam int ACC_PAD = PC_W - BYTE_W;

    logic [PC_W-1:0] adv;
    logic [PC_W-1:0] nxt;
    tgt_set_t        tgts;
    flow_e           kind;

    always_comb kind = flow_decode(flow);

    nextpc_advance #(.W(PC_W), .LW(LEN_W)) u_adv (
        .pc  (cur_pc),
        .len (instr_len),
        .adv (adv)
    );

    nextpc_targets #(.OFFSET_LAST_BYTE(1'b1)) u_tgt (
        .adv    (adv),
        .len    (instr_len),
        .opcode (opcode),
        .op1    (operand1),
        .op2    (operand2),
        .acc    (acc),
        .dptr   (dptr),
        .tgts   (tgts)
    );

    nextpc_select u_sel (
        .kind  (kind),
        .taken (taken),
        .adv   (adv),
        .tgts  (tgts),
        .nxt   (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) next_pc <= RESET_VEC;
        else     next_pc <= nxt;
    end

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (flow == 3'd0) |=> next_pc == $past(cur_pc + {{LEN_PAD{1'b0}}, instr_len})); // R2
    AST_PAGE_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (flow == 3'd1) |=> next_pc[PC_W-1:PAGE_W] ==
            $past(PC_W'(cur_pc + {{LEN_PAD{1'b0}}, instr_len}) >> PAGE_W)); // R4
    AST_PAGE_LOW: assert property (@(posedge clk) disable iff (rst)
        (flow == 3'd1) |=> next_pc[PAGE_W-1:0] == $past({opcode[7:5], operand1})); // R3
    AST_LONG_LOAD: assert property (@(posedge clk) disable iff (rst)
        (flow == 3'd2) |=> next_pc == $past({operand1, operand2})); // R5
    AST_REL_FALL: assert property (@(posedge clk) disable iff (rst)
        (flow == 3'd3 && !taken) |=> next_pc == $past(cur_pc + {{LEN_PAD{1'b0}}, instr_len})); // R7
    AST_INDIR_SUM: assert property (@(posedge clk) disable iff (rst)
        (flow == 3'd4) |=> next_pc == $past(dptr + {{ACC_PAD{1'b0}}, acc})); // R8
    AST_SPARE_SEQ: assert property (@(posedge clk) disable iff (rst)
        (flow >= 3'd5) |=> next_pc == $past(cur_pc + {{LEN_PAD{1'b0}}, instr_len})); // R10
endmodule

// File: tb/nextpc_unit_test.sv
module nextpc_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cur_pc = '0;
    logic [1:0]  instr_len = '0;
    logic [2:0]  flow = '0;
    logic [7:0]  opcode = '0, operand1 = '0, operand2 = '0, acc = '0;
    logic [15:0] dptr = '0;
    logic        taken = 1'b0;
    logic [15:0] next_pc;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    nextpc_unit uut (
        .clk(clk), .rst(rst), .cur_pc(cur_pc), .instr_len(instr_len),
        .flow(flow), .opcode(opcode), .operand1(operand1), .operand2(operand2),
        .acc(acc), .dptr(dptr), .taken(taken), .next_pc(next_pc)
    );

    task automatic check(input string req, input logic [15:0] exp);
        total++;
        if (next_pc !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, next_pc, exp);
        end
    endtask

    // drive at falling edge, capture at rising edge, sample at next falling edge
    task automatic step(input logic [2:0] f, input logic [15:0] pc, input logic [1:0] len,
                        input logic [7:0] opc, input logic [7:0] o1, input logic [7:0] o2,
                        input logic [7:0] a, input logic [15:0] dp, input logic tk);
        @(negedge clk);
        flow = f; cur_pc = pc; instr_len = len; opcode = opc;
        operand1 = o1; operand2 = o2; acc = a; dptr = dp; taken = tk;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        step(3'd2, 16'h1234, 2'd3, 8'h02, 8'hAB, 8'hCD, 8'h00, 16'h0000, 1'b1);
        check("R1 reset vector", 16'h0000);
        rst = 1'b0;
    endtask

    task automatic t_sequential();
        step(3'd0, 16'h1234, 2'd1, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0);
        check("R2 seq len1", 16'h1235);
        step(3'd0, 16'h1234, 2'd3, 8'h00, 8'h11, 8'h22, 8'h00, 16'h0000, 1'b0);
        check("R2 seq len3", 16'h1237);
        step(3'd0, 16'hFFFF, 2'd1, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b0);
        check("R9 seq wrap", 16'h0000);
    endtask

    task automatic t_page();
        step(3'd1, 16'h0345, 2'd2, 8'h21, 8'h23, 8'h00, 8'h00, 16'h0000, 1'b0);
        check("R3 in-block jump", 16'h0123);
        step(3'd1, 16'h07FE, 2'd2, 8'hE1, 8'h55, 8'h00, 8'h00, 16'h0000, 1'b0);
        check("R4 block crossing", 16'h0F55);
        step(3'd1, 16'hA345, 2'd2, 8'h51, 8'h9A, 8'h00, 8'h00, 16'h0000, 1'b1);
        check("R11 in-block taken ignored", 16'hA29A);
    endtask

    task automatic t_long();
        step(3'd2, 16'h0100, 2'd3, 8'h02, 8'hAB, 8'hCD, 8'h00, 16'h0000, 1'b0);
        check("R5 long jump", 16'hABCD);
    endtask

    task automatic t_relative();
        step(3'd3, 16'h1000, 2'd2, 8'h80, 8'h10, 8'h99, 8'h00, 16'h0000, 1'b1);
        check("R6 rel forward", 16'h1012);
        step(3'd3, 16'h1000, 2'd2, 8'h80, 8'h80, 8'h00, 8'h00, 16'h0000, 1'b1);
        check("R6 rel -128", 16'h0F82);
        step(3'd3, 16'h1000, 2'd2, 8'h80, 8'h7F, 8'h00, 8'h00, 16'h0000, 1'b1);
        check("R6 rel +127", 16'h1081);
        step(3'd3, 16'h2000, 2'd3, 8'hB5, 8'h44, 8'hFE, 8'h00, 16'h0000, 1'b1);
        check("R6 rel last byte", 16'h2001);
        step(3'd3, 16'h2000, 2'd3, 8'hB5, 8'h44, 8'hFE, 8'h00, 16'h0000, 1'b0);
        check("R7 rel fall through", 16'h2003);
        step(3'd3, 16'hFFFE, 2'd2, 8'h80, 8'h05, 8'h00, 8'h00, 16'h0000, 1'b1);
        check("R9 rel forward wrap", 16'h0005);
        step(3'd3, 16'h0000, 2'd2, 8'h80, 8'hF0, 8'h00, 8'h00, 16'h0000, 1'b1);
        check("R9 rel backward wrap", 16'hFFF2);
    endtask

    task automatic t_indirect();
        step(3'd4, 16'h0050, 2'd1, 8'h73, 8'h00, 8'h00, 8'hF0, 16'h1200, 1'b0);
        check("R8 indirect", 16'h12F0);
        step(3'd4, 16'h0050, 2'd1, 8'h73, 8'h00, 8'h00, 8'h20, 16'hFFF0, 1'b1);
        check("R9 indirect wrap", 16'h0010);
    endtask

    task automatic t_spare_and_taken();
        step(3'd6, 16'h4000, 2'd2, 8'h01, 8'h77, 8'h88, 8'h00, 16'h0000, 1'b1);
        check("R10 spare code 6", 16'h4002);
        step(3'd5, 16'h4000, 2'd3, 8'h01, 8'h77, 8'h88, 8'h00, 16'h0000, 1'b0);
        check("R10 spare code 5", 16'h4003);
        step(3'd7, 16'h4100, 2'd1, 8'h01, 8'h77, 8'h88, 8'h00, 16'h0000, 1'b0);
        check("R10 spare code 7", 16'h4101);
        step(3'd0, 16'h5000, 2'd1, 8'h00, 8'h10, 8'h00, 8'h00, 16'h0000, 1'b1);
        check("R11 seq taken ignored", 16'h5001);
    endtask

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_sequential();
        t_page();
        t_long();
        t_relative();
        t_indirect();
        t_spare_and_taken();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule